// File: doc/BRIEF.md
# BCD Event Counter with Match Alarm

This block counts rising edges on an asynchronous event input, holding the count as six packed-BCD digits (000000 to 999999) in three byte registers. Software reaches it through a plain synchronous register port: a write strobe with address and data, and a combinational read path. Counting happens only while the mode field of the control register selects event counting. The count is compared every cycle against a six-digit alarm value held in three separate registers. When the two are equal and the alarm-select field enables the event alarm, a sticky alarm flag is raised.

The active-low interrupt output has two uses. With the alarm-enable bit of the control register clear, it carries a 1 Hz square wave derived from the reference clock. With that bit set, it shows the inverted alarm flag, provided the interrupt-enable bit is set. Otherwise it stays high.

Two small state machines carry the state. The flag machine has the states FLAG_IDLE and FLAG_HELD. Its transitions are "hit" (FLAG_IDLE to FLAG_HELD on a qualified match) and "release" (FLAG_HELD to FLAG_IDLE on a software clear while no match is present). The wave machine has the states WAVE_LOW and WAVE_HIGH. Its single transition, "half elapsed", toggles the state each time the divider reaches the end of half a period.

Top module: `bcd_event_counter`

Register map (4-bit address, 8-bit data):

| Addr | Contents |
|------|----------|
| 0h | control: bits 5:4 mode (10 = event counting), bit 2 alarm enable, bit 1 alarm flag, other bits plain storage |
| 1h, 2h, 3h | count bytes, least significant first; low nibble is the lower digit |
| 8h | alarm control: bits 5:4 alarm select (01 = event alarm), bit 7 interrupt enable, other bits plain storage |
| 9h, Ah, Bh | alarm value bytes, same digit layout as the count |

## Requirements
- R1: After reset, every mapped register reads 0 and `irq_n` is high.
- R2: While control bits 5:4 equal binary 10, each rising edge of `evt_in` adds one to the count. The edge is seen through a two-flop synchronizer, so the count changes on the third rising clock edge after `evt_in` is sampled high. With any other mode value, edges leave the count unchanged.
- R3: The count advances in decimal: a digit at 9 returns to 0 and carries into the next digit. 999999 wraps to 000000.
- R4: A write to address 1h, 2h or 3h loads that count byte directly. A write in the same cycle as a counted edge wins, and no increment is applied in that cycle.
- R5: Control bit 1 (the alarm flag) is set one cycle after all of the following hold: the count equals the value in 9h to Bh, control bits 5:4 equal 10, and alarm-control bits 5:4 equal 01.
- R6: The flag stays set until a write to address 0h with bit 1 at 0 while no match is present. A write with bit 1 at 1 leaves the flag unchanged.
- R7: With control bit 2 at 1, `irq_n` equals the inverted flag when alarm-control bit 7 is 1, and is 1 when that bit is 0.
- R8: With control bit 2 at 0, `irq_n` is a square wave with a period of `CLK_HZ` clock cycles and a 50 percent duty cycle.
- R9: Addresses other than 0h, 1h to 3h, 8h and 9h to Bh read 0, and writes to them change no register.
- R10: With alarm-control bits 5:4 at any value other than 01, an equal count does not set the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, `CLK_HZ` cycles per second |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_in | input | 1 | Asynchronous event pulse input |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data, combinational from `addr` |
| irq_n | output | 1 | Active-low interrupt or 1 Hz square wave |

## Verification
The bench builds the block with `CLK_HZ` set to 8. This makes the 1 Hz period only eight cycles, so several full periods of the square wave can be timed cycle by cycle in a short run. The counter keeps its full six digits, so the 999999 wrap, multi-digit carries and the write-versus-edge collision can be reached directly by loading the count bytes. Random edge trains mixed with mode changes and BCD loads are checked against a decimal model kept in the bench.

// File: rtl/bcd_evt_pkg.sv
package bcd_evt_pkg;
    localparam int DIGITS  = 6;
    localparam int BYTES   = DIGITS / 2;
    localparam int CNT_W   = 4 * DIGITS;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 8;

    localparam logic [ADDR_W-1:0] A_CTRL = 4'h0;
    localparam logic [ADDR_W-1:0] A_CNT0 = 4'h1;
    localparam logic [ADDR_W-1:0] A_ACTL = 4'h8;
    localparam logic [ADDR_W-1:0] A_ALM0 = 4'h9;

    localparam logic [1:0] MODE_EVENT = 2'b10;
    localparam logic [1:0] SEL_EVENT  = 2'b01;

    localparam int BIT_FLAG = 1;
    localparam int BIT_AEN  = 2;
    localparam int BIT_IEN  = 7;

    typedef enum logic {
        FLAG_IDLE,
        FLAG_HELD
    } flag_state_t;

    typedef enum logic {
        WAVE_LOW,
        WAVE_HIGH
    } wave_state_t;
endpackage

// File: rtl/evt_edge_sync.sv
module evt_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-1:0], din};
        end
    end

    // synchronized level is chain_q[STAGES-1]; chain_q[STAGES] is its last value
    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/bcd_digit_chain.sv
module bcd_digit_chain #(
    parameter int DIGITS = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  inc,
    input  logic [DIGITS/2-1:0]   ld_en,
    input  logic [7:0]            ld_data,
    output logic [4*DIGITS-1:0]   cnt
);
    logic [DIGITS:0] carry;

    // any load in this cycle suppresses the increment everywhere
    assign carry[0] = inc & ~(|ld_en);

    for (genvar i = 0; i < DIGITS; i++) begin : g_digit
        logic [3:0] dq;
        logic       at_nine;

        assign at_nine    = (dq == 4'd9);
        assign carry[i+1] = carry[i] & at_nine;
        assign cnt[4*i +: 4] = dq;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dq <= 4'd0;
            end else if (ld_en[i/2]) begin
                dq <= ld_data[4*(i%2) +: 4];
            end else if (carry[i]) begin
                dq <= at_nine ? 4'd0 : dq + 4'd1;
            end
        end
    end

    logic unused_top_carry;
    assign unused_top_carry = carry[DIGITS];
endmodule

// File: rtl/evt_flag_fsm.sv
module evt_flag_fsm
    import bcd_evt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr_req,
    output logic flag
);
    flag_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: if (hit) state_d = FLAG_HELD;
            FLAG_HELD: if (clr_req && !hit) state_d = FLAG_IDLE;
            default:   state_d = FLAG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLAG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            FLAG_HELD: flag = 1'b1;
            default:   flag = 1'b0;
        endcase
    end
endmodule

// File: rtl/hz_wave_gen.sv
module hz_wave_gen
    import bcd_evt_pkg::*;
#(
    parameter int CLK_HZ = 32768
) (
    input  logic clk,
    input  logic rst_n,
    output logic wave
);
    localparam int HALF = (CLK_HZ / 2 > 0) ? CLK_HZ / 2 : 1;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] TERM = CW'(HALF - 1);

    logic [CW-1:0] div_q;
    logic          half_done;
    wave_state_t   state_q, state_d;

    assign half_done = (div_q == TERM);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (half_done) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WAVE_LOW:  if (half_done) state_d = WAVE_HIGH;
            WAVE_HIGH: if (half_done) state_d = WAVE_LOW;
            default:   state_d = WAVE_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WAVE_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            WAVE_HIGH: wave = 1'b1;
            default:   wave = 1'b0;
        endcase
    end
endmodule

// File: rtl/bcd_event_counter.sv
module bcd_event_counter
    import bcd_evt_pkg::*;
#(
    parameter int CLK_HZ = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_n
);
    logic [7:2]       ctrl_hi_q;
    logic             ctrl_b0_q;
    logic [7:0]       actl_q;
    logic [CNT_W-1:0] alm_vec;
    logic [CNT_W-1:0] cnt_q;
    logic [BYTES-1:0] cnt_ld;
    logic             evt_rise;
    logic             evt_inc;
    logic             alarm_hit;
    logic             flag_clr;
    logic             alarm_flag;
    logic             wave;
    logic             mode_event;
    logic             sel_event;
    logic             wr_ctrl;
    logic             wr_actl;

    assign wr_ctrl    = wr_en && (addr == A_CTRL);
    assign wr_actl    = wr_en && (addr == A_ACTL);
    assign mode_event = (ctrl_hi_q[5:4] == MODE_EVENT);
    assign sel_event  = (actl_q[5:4] == SEL_EVENT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_hi_q <= '0;
            ctrl_b0_q <= 1'b0;
        end else if (wr_ctrl) begin
            ctrl_hi_q <= wdata[7:2];
            ctrl_b0_q <= wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            actl_q <= '0;
        end else if (wr_actl) begin
            actl_q <= wdata;
        end
    end

    for (genvar j = 0; j < BYTES; j++) begin : g_byte
        logic [7:0] alm_q;

        assign cnt_ld[j] = wr_en && (addr == A_CNT0 + ADDR_W'(j));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                alm_q <= '0;
            end else if (wr_en && (addr == A_ALM0 + ADDR_W'(j))) begin
                alm_q <= wdata;
            end
        end

        assign alm_vec[8*j +: 8] = alm_q;
    end

    evt_edge_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (evt_in),
        .rise  (evt_rise)
    );

    assign evt_inc = evt_rise && mode_event;

    bcd_digit_chain #(.DIGITS(DIGITS)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (evt_inc),
        .ld_en   (cnt_ld),
        .ld_data (wdata),
        .cnt     (cnt_q)
    );

    assign alarm_hit = mode_event && sel_event && (cnt_q == alm_vec);
    assign flag_clr  = wr_ctrl && !wdata[BIT_FLAG];

    evt_flag_fsm u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit     (alarm_hit),
        .clr_req (flag_clr),
        .flag    (alarm_flag)
    );

    hz_wave_gen #(.CLK_HZ(CLK_HZ)) u_wave (
        .clk   (clk),
        .rst_n (rst_n),
        .wave  (wave)
    );

    always_comb begin
        if (!ctrl_hi_q[BIT_AEN]) begin
            irq_n = ~wave;
        end else if (actl_q[BIT_IEN]) begin
            irq_n = ~alarm_flag;
        end else begin
            irq_n = 1'b1;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == A_CTRL) begin
            rdata = {ctrl_hi_q, alarm_flag, ctrl_b0_q};
        end else if (addr == A_ACTL) begin
            rdata = actl_q;
        end
        for (int j = 0; j < BYTES; j++) begin
            if (addr == A_CNT0 + ADDR_W'(j)) rdata = cnt_q[8*j +: 8];
            if (addr == A_ALM0 + ADDR_W'(j)) rdata = alm_vec[8*j +: 8];
        end
    end
endmodule

// File: rtl/evt_counter_chk.sv
module evt_counter_chk
    import bcd_evt_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             inc,
    input logic [BYTES-1:0] ld,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] alm,
    input logic             mode_ev,
    input logic             sel_ev,
    input logic             clr,
    input logic             flag,
    input logic             aen,
    input logic             ien,
    input logic             irq_n
);
    // R2: one counted edge lasts one cycle only
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> !inc);

    // R2: no edge and no load leaves the count alone
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && ld == '0) |=> $stable(cnt));

    // R3: full-scale wrap
    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && ld == '0 && cnt == 24'h999999) |=> (cnt == '0));

    // R4: a load blocks the increment of untouched bytes
    p_load_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && ld[0]) |=> $stable(cnt[CNT_W-1:8]));

    // R5: qualified match raises the flag
    p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ev && sel_ev && cnt == alm) |=> flag);

    // R6: flag only drops after a clear request
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    // R7: a freshly raised flag pulls the output low when routed
    p_irq_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(flag) && aen && ien) |-> !irq_n);
endmodule

bind bcd_event_counter evt_counter_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (evt_inc),
    .ld      (cnt_ld),
    .cnt     (cnt_q),
    .alm     (alm_vec),
    .mode_ev (mode_event),
    .sel_ev  (sel_event),
    .clr     (flag_clr),
    .flag    (alarm_flag),
    .aen     (ctrl_hi_q[2]),
    .ien     (actl_q[7]),
    .irq_n   (irq_n)
);

// File: tb/bcd_event_counter_tb.sv
module bcd_event_counter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TB_HZ      = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_in = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [23:0] model = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_event_counter #(.CLK_HZ(TB_HZ)) u_dut (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n)
    );

    function automatic logic [23:0] bcd_next(input logic [23:0] v);
        logic [23:0] r = v;
        for (int i = 0; i < 6; i++) begin
            if (r[4*i +: 4] == 4'd9) begin
                r[4*i +: 4] = 4'd0;
            end else begin
                r[4*i +: 4] = r[4*i +: 4] + 4'd1;
                break;
            end
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic rd_cnt(output logic [23:0] v);
        logic [7:0] b;
        for (int j = 0; j < 3; j++) begin
            rd(4'(1 + j), b);
            v[8*j +: 8] = b;
        end
    endtask

    task automatic load_cnt(input logic [23:0] v);
        for (int j = 0; j < 3; j++) wr(4'(1 + j), v[8*j +: 8]);
    endtask

    task automatic pulse();
        @(negedge clk); evt_in = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); evt_in = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle();
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [23:0] c;
        logic        prev;
        int          len;
        void'($urandom(32'd4242));

        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset values
        chk("R1 irq_n", irq_n, 1'b1);
        foreach (b[i]) begin end
        for (int k = 0; k < 12; k++) begin
            if (k == 0 || (k >= 1 && k <= 3) || k >= 8) begin
                rd(4'(k), b);
                chk("R1 reg", b, 8'h00);
            end
        end

        // R8: square wave, half period TB_HZ/2 cycles
        @(negedge clk); prev = irq_n;
        len = 0;
        while (irq_n == prev && len < 20) begin @(negedge clk); len++; end
        for (int t = 0; t < 3; t++) begin
            prev = irq_n; len = 0;
            while (irq_n == prev && len < 20) begin @(negedge clk); len++; end
            chk("R8 half period", len, TB_HZ / 2);
        end

        // R2: mode 00 ignores edges
        pulse(); pulse();
        rd_cnt(c); chk("R2 mode off", c, 24'h0);
        wr(4'h0, 8'h30); pulse();
        rd_cnt(c); chk("R2 mode 11", c, 24'h0);
        wr(4'h0, 8'h20);
        for (int k = 0; k < 5; k++) pulse();
        rd_cnt(c); chk("R2 five edges", c, 24'h000005);

        // R3: carries and wrap
        load_cnt(24'h000199); pulse();
        rd_cnt(c); chk("R3 carry", c, 24'h000200);
        load_cnt(24'h999999); pulse();
        rd_cnt(c); chk("R3 wrap", c, 24'h000000);
        load_cnt(24'h000200);

        // R4: write collides with a counted edge
        @(negedge clk); evt_in = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk); wr_en = 1'b1; addr = 4'h1; wdata = 8'h42;
        @(negedge clk); wr_en = 1'b0; evt_in = 1'b0;
        settle();
        rd_cnt(c); chk("R4 load priority", c, 24'h000242);

        // R5: match sets flag
        wr(4'h9, 8'h10); wr(4'h8, 8'h10);
        load_cnt(24'h000008); pulse();
        rd(4'h0, b); chk("R5 no match", b[1], 1'b0);
        pulse();
        rd(4'h0, b); chk("R5 flag set", b[1], 1'b1);

        // R6: sticky and clear
        pulse();
        rd(4'h0, b); chk("R6 sticky", b[1], 1'b1);
        wr(4'h0, 8'h22); settle();
        rd(4'h0, b); chk("R6 write one", b, 8'h22);
        wr(4'h0, 8'h20); settle();
        rd(4'h0, b); chk("R6 clear", b, 8'h20);

        // R7: interrupt routing
        wr(4'h0, 8'h24); wr(4'h8, 8'h90); settle();
        chk("R7 idle high", irq_n, 1'b1);
        load_cnt(24'h000010); settle();
        chk("R7 flag low", irq_n, 1'b0);
        wr(4'h8, 8'h10); settle();
        chk("R7 ien off", irq_n, 1'b1);

        // R10: wrong alarm select
        wr(4'h8, 8'h20); wr(4'h0, 8'h24); settle();
        rd(4'h0, b); chk("R10 no flag", b[1], 1'b0);
        load_cnt(24'h000000); load_cnt(24'h000010); settle();
        rd(4'h0, b); chk("R10 no flag equal", b[1], 1'b0);

        // R9: unmapped address
        wr(4'h5, 8'hFF);
        rd(4'h5, b); chk("R9 read zero", b, 8'h00);
        rd(4'h0, b); chk("R9 ctrl kept", b, 8'h24);
        rd(4'h8, b); chk("R9 actl kept", b, 8'h20);
        rd_cnt(c); chk("R9 count kept", c, 24'h000010);

        // R2 R3: random traffic against decimal model
        wr(4'h8, 8'h00);
        model = 24'h000010;
        for (int it = 0; it < 150; it++) begin
            int op = $urandom % 10;
            if (op < 6) begin
                pulse();
                if (mode_is_event()) model = bcd_next(model);
            end else if (op < 8) begin
                wr(4'h0, ($urandom % 2) ? 8'h20 : 8'h10);
            end else begin
                for (int j = 0; j < 3; j++)
                    c[8*j +: 8] = {4'($urandom % 10), 4'($urandom % 10)};
                if (op == 9) c = 24'h999998;
                load_cnt(c);
                model = c;
            end
            if (it % 10 == 9) begin
                rd_cnt(c); chk("R2 R3 random", c, model);
            end
        end
        rd_cnt(c); chk("R3 random final", c, model);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    function automatic bit mode_is_event();
        return u_dut.rdata === u_dut.rdata && cur_mode == 2'b10;
    endfunction

    logic [1:0] cur_mode = 2'b00;
    always @(negedge clk) if (wr_en && addr == 4'h0) cur_mode <= wdata[5:4];
endmodule